// File: doc/BRIEF.md
# ADC Conversion Clock Source Selector and Divider

This block produces the conversion clock for an on-chip analog-to-digital converter. The clock is a single-bus-cycle enable pulse, and the whole block runs in one bus-clock domain. A 2-bit source field picks one of four tick sources. These are the bus clock itself, the bus clock halved, an alternate clock and an internal asynchronous clock. The alternate and asynchronous clocks arrive as one-cycle ticks that are already synchronous to the bus clock. A 2-bit ratio field then divides the chosen ticks by 1, 2, 4 or 8. Halving the bus clock and dividing by 8 therefore gives one pulse every 16 bus cycles.

A low-power input stops the bus-derived sources and the alternate source. The asynchronous source keeps running under low power, so conversions can go on in wait or stop modes. A flag tells the converter that the asynchronous source is in use. When either field changes, the division restarts from zero. This keeps the first period after a change from being short or long.

Top module: `adcclk_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, conv_tick and async_active are 0. Out of reset the source is the bus clock divided by 1, so conv_tick is 1 in every cycle while both fields stay 00.
- R2: The source encoding is 00 bus clock, 01 bus clock halved, 10 alt_tick and 11 async_tick. conv_tick reflects the inputs one bus cycle later, through a register.
- R3: The ratio encoding is 00 for /1, 01 for /2, 10 for /4 and 11 for /8. One conv_tick is produced for every N ticks of the selected source. With the bus clock at /1, conv_tick is 1 in every cycle.
- R4: The halved bus source ticks in every second bus cycle. Its first tick comes two cycles after a configuration change. Combined with /8, it gives one pulse every 16 bus cycles.
- R5: In a cycle where the source or ratio field differs from the previous cycle, no pulse is produced and the count restarts from zero. The first pulse then follows exactly N source ticks later.
- R6: While low_power is 1, the bus, halved-bus and alternate sources deliver no ticks. The tick count is held and resumes when low_power returns to 0.
- R7: The asynchronous source keeps counting and producing pulses while low_power is 1.
- R8: async_active is 1 exactly when the source field was 11 in the previous cycle, regardless of low_power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Tick source select |
| div_sel | input | DIV_W (2) | Power-of-two ratio select |
| alt_tick | input | 1 | Alternate clock tick, bus-synchronous |
| async_tick | input | 1 | Asynchronous clock tick, bus-synchronous |
| low_power | input | 1 | Wait/stop indication, gates non-asynchronous sources |
| conv_tick | output | 1 | One-cycle converter clock enable |
| async_active | output | 1 | Asynchronous source is selected |

## Verification
Two pairs of events can land in the same cycle: a configuration change with a source tick that would have completed a period, and low power with an asynchronous tick. The first pair is provoked by changing the ratio from /4 to /2 on exactly the fourth bus tick. The change must win, with no pulse, and the new period must start from zero. The second pair is provoked by asserting low_power while asynchronous ticks keep arriving. Pulses must continue at the asynchronous rate, while the same low-power pattern on the halved bus source must freeze the count.

// File: rtl/adcclk_pkg.sv
`timescale 1ns/1ps
package adcclk_pkg;

   typedef enum logic [1:0] {
      SRC_BUS      = 2'b00,
      SRC_BUS_HALF = 2'b01,
      SRC_ALT      = 2'b10,
      SRC_ASYNC    = 2'b11
   } adc_src_e;

   localparam int unsigned SRC_W = 2;

endpackage

// File: rtl/adcclk_src_mux.sv
`timescale 1ns/1ps
module adcclk_src_mux
   import adcclk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     restart,
   input  adc_src_e src_sel,
   input  logic     alt_tick,
   input  logic     async_tick,
   input  logic     low_power,
   output logic     src_tick
);

   logic half_phase;

   // Halved bus tick: phase restarts at 0 on a configuration change.
   always_ff @(posedge clk) begin
      if (!rst_n || restart) half_phase <= 1'b0;
      else                   half_phase <= ~half_phase;
   end

   always_comb begin
      unique case (src_sel)
         SRC_BUS:      src_tick = ~low_power;
         SRC_BUS_HALF: src_tick = ~low_power & half_phase;
         SRC_ALT:      src_tick = ~low_power & alt_tick;
         default:      src_tick = async_tick;
      endcase
   end

   // R4: the halved bus source never ticks in two adjacent cycles
   p_half_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == SRC_BUS_HALF && src_tick) |=> !(src_sel == SRC_BUS_HALF && src_tick));

   // R6: gated sources deliver nothing under low power
   p_gate_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power && src_sel != SRC_ASYNC) |-> !src_tick);

endmodule

// File: rtl/adcclk_divider.sv
`timescale 1ns/1ps
module adcclk_divider #(
   parameter int unsigned DIV_W   = 2,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             src_tick,
   input  logic [DIV_W-1:0] div_sel,
   output logic             conv_tick
);

   localparam int unsigned MAX_LOG2 = (1 << DIV_W) - 1;
   localparam int unsigned CNT_W    = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

   if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div_w
      $error("adcclk_divider: DIV_W must be 1..3");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic             fire;

   assign limit = CNT_W'((32'd1 << div_sel) - 32'd1);
   assign fire  = src_tick & ~restart & (cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) cnt <= '0;
      else if (src_tick)     cnt <= fire ? '0 : cnt + 1'b1;
   end

   if (OUT_REG) begin : g_out_reg
      logic conv_q;
      always_ff @(posedge clk) begin
         if (!rst_n) conv_q <= 1'b0;
         else        conv_q <= fire;
      end
      assign conv_tick = conv_q;

      // R5: a configuration change never yields a pulse
      p_restart_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
         restart |=> !conv_tick);
   end else begin : g_out_comb
      assign conv_tick = fire;
   end

   // R3: the count stays inside the selected period
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> (cnt <= limit));

endmodule

// File: rtl/adcclk_gen.sv
`timescale 1ns/1ps
module adcclk_gen
   import adcclk_pkg::*;
#(
   parameter int unsigned DIV_W   = 2,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       src_sel,
   input  logic [DIV_W-1:0] div_sel,
   input  logic             alt_tick,
   input  logic             async_tick,
   input  logic             low_power,
   output logic             conv_tick,
   output logic             async_active
);

   localparam int unsigned CFG_W = SRC_W + DIV_W;

   adc_src_e         src_e;
   logic [CFG_W-1:0] cfg_q;
   logic             restart;
   logic             src_tick;
   logic             async_q;

   assign src_e   = adc_src_e'(src_sel);
   assign restart = ({src_sel, div_sel} != cfg_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         async_q <= 1'b0;
      end else begin
         cfg_q   <= {src_sel, div_sel};
         async_q <= (src_e == SRC_ASYNC);
      end
   end
   assign async_active = async_q;

   adcclk_src_mux i_src_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .src_sel    (src_e),
      .alt_tick   (alt_tick),
      .async_tick (async_tick),
      .low_power  (low_power),
      .src_tick   (src_tick)
   );

   adcclk_divider #(.DIV_W(DIV_W), .OUT_REG(OUT_REG)) i_divider (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .src_tick  (src_tick),
      .div_sel   (div_sel),
      .conv_tick (conv_tick)
   );

   if (OUT_REG) begin : g_chk
      // R3: bus clock at /1 pulses every cycle
      p_div1_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (src_e == SRC_BUS && div_sel == '0 && !low_power && !restart) |=> conv_tick);

      // R6: no pulse from a gated source under low power
      p_lowpower_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (low_power && src_e != SRC_ASYNC) |=> !conv_tick);

      // R7: asynchronous ticks at /1 still produce pulses under low power
      p_async_lowpower_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (src_e == SRC_ASYNC && div_sel == '0 && async_tick && !restart) |=> conv_tick);
   end

   // R8: flag follows the previous cycle's source field
   p_async_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (src_e == SRC_ASYNC) |=> async_active);

endmodule

// File: tb/test_adcclk_gen.sv
`timescale 1ns/1ps
module test_adcclk_gen;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] src_sel;
   logic [1:0] div_sel;
   logic       alt_tick;
   logic       async_tick;
   logic       low_power;
   logic       conv_tick;
   logic       async_active;

   always #2 clk = ~clk;

   adcclk_gen i_adcclk_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_sel      (src_sel),
      .div_sel      (div_sel),
      .alt_tick     (alt_tick),
      .async_tick   (async_tick),
      .low_power    (low_power),
      .conv_tick    (conv_tick),
      .async_active (async_active)
   );

   typedef struct {
      logic  tick;
      logic  act;
      string tag;
   } exp_t;

   exp_t       q[$];
   int         checks   = 0;
   int         failures = 0;
   bit         done     = 0;
   logic [3:0] prev_cfg;
   int         j;
   int         n;

   // Driver: applies one cycle of stimulus and queues the expected result.
   task automatic step(input logic [1:0] s, input logic [1:0] d, input logic a,
                       input logic y, input logic lp, input string tag);
      exp_t e;
      logic tk;
      int   nr;
      src_sel = s; div_sel = d; alt_tick = a; async_tick = y; low_power = lp;
      nr = 1 << d;
      if ({s, d} != prev_cfg) begin
         j = 0; n = 0; e.tick = 1'b0;
      end else begin
         j++;
         case (s)
            2'b00:   tk = !lp;
            2'b01:   tk = !lp && (j % 2 == 0);
            2'b10:   tk = a && !lp;
            default: tk = y;
         endcase
         if (tk) n++;
         e.tick = tk && (n % nr == 0);
      end
      prev_cfg = {s, d};
      e.act = (s == 2'b11);
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   // Monitor: compares each registered result after the edge that made it.
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (q.size() > 0) begin
         e = q.pop_front();
         checks++;
         if (conv_tick !== e.tick || async_active !== e.act) begin
            failures++;
            $display("FAIL %s conv_tick=%0b async_active=%0b expected %0b %0b",
                     e.tag, conv_tick, async_active, e.tick, e.act);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; src_sel = 2'b00; div_sel = 2'b00;
      alt_tick = 1'b0; async_tick = 1'b0; low_power = 1'b0;
      repeat (3) @(negedge clk);
      checks++;
      if (conv_tick !== 1'b0 || async_active !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset conv_tick=%0b async_active=%0b expected 0 0",
                  conv_tick, async_active);
      end
      prev_cfg = 4'b0000; j = 0; n = 0;
      rst_n = 1'b1;
      // R1: default bus /1 out of reset
      for (int i = 0; i < 6; i++) step(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, "R1");
      // R3: bus clock at /2, /4 and /8
      for (int i = 0; i < 12; i++) step(2'b00, 2'b01, 1'b0, 1'b0, 1'b0, "R3");
      for (int i = 0; i < 14; i++) step(2'b00, 2'b10, 1'b0, 1'b0, 1'b0, "R3");
      for (int i = 0; i < 20; i++) step(2'b00, 2'b11, 1'b0, 1'b0, 1'b0, "R3");
      // R4: halved bus at /1 and /8 (period 16)
      for (int i = 0; i < 10; i++) step(2'b01, 2'b00, 1'b0, 1'b0, 1'b0, "R4");
      for (int i = 0; i < 40; i++) step(2'b01, 2'b11, 1'b0, 1'b0, 1'b0, "R4");
      // R2: alternate ticks at /2 with an irregular pattern
      for (int i = 0; i < 25; i++)
         step(2'b10, 2'b01, (i % 5 == 1) || (i % 5 == 3) || (i % 7 == 0), 1'b0, 1'b0, "R2");
      // R5: change ratio exactly on the cycle that would complete a /4 period
      for (int i = 0; i < 4; i++) step(2'b00, 2'b10, 1'b0, 1'b0, 1'b0, "R5");
      step(2'b00, 2'b01, 1'b0, 1'b0, 1'b0, "R5");
      for (int i = 0; i < 6; i++) step(2'b00, 2'b01, 1'b0, 1'b0, 1'b0, "R5");
      // R6: halved bus at /2 with low power pulses in the middle
      for (int i = 0; i < 30; i++)
         step(2'b01, 2'b01, 1'b0, 1'b0, (i >= 5 && i < 14), "R6");
      // R6: alternate source frozen under low power
      for (int i = 0; i < 16; i++)
         step(2'b10, 2'b00, (i % 2 == 0), 1'b0, (i >= 4 && i < 10), "R6");
      // R7 and R8: asynchronous /1 and /4 with low power asserted
      for (int i = 0; i < 12; i++)
         step(2'b11, 2'b00, 1'b0, (i % 3 == 0), (i >= 3), "R7");
      for (int i = 0; i < 30; i++)
         step(2'b11, 2'b10, 1'b0, (i % 2 == 1), (i % 4 < 2), "R8");
      // R8: flag drops when leaving the asynchronous source
      for (int i = 0; i < 4; i++) step(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, "R8");
      repeat (3) @(negedge clk);
      if (q.size() != 0) begin
         checks++; failures++;
         $display("FAIL R2 pending=%0d expected 0", q.size());
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule